// File: doc/BRIEF.md
# Embedded Operation Status Read Path

This block forms the byte a host sees when it reads a non-volatile array while a self-timed program or erase operation may be running. The operation engine tells it when an operation begins (the rising edge of the second strobe of the two-write command sequence), whether the operation is a program or an erase, and whether it is still busy. The block latches the last written data byte at that start point. On every read it returns one byte.

While an operation is busy and its start has been seen, two bits of the returned byte are replaced with progress flags. The upper flag is a data poll. During a program it returns the inverse of the written value for that bit. During an erase it returns 0. The flag below it flips on every read. All other bits return 0. Once the engine drops busy, reads pass the array byte straight through, so the flipping bit settles. A host treats the operation as finished after two reads in a row show the same flip bit.

Each read is taken on the leading edge of the read strobe and registered. A strobe that stays high for many clocks counts as a single read.

Top module: `busy_status_rd`

## Requirements
- R1: After reset, `rd_data` is 0x00.
- R2: On a read when no started operation is busy, `rd_data` takes the value of `array_data` sampled at the read's leading edge.
- R3: On successive reads while a started operation is busy, bit 6 of `rd_data` alternates. The first such read after a start returns 1.
- R4: A read is counted only on the first clock of a strobe pulse. While the strobe stays high, `rd_data` holds its value and the bit-6 sequence does not advance.
- R5: During a busy program, bit 7 of `rd_data` is the inverse of bit 7 of `wr_data` as latched at `op_start`.
- R6: During a busy erase (`op_is_erase`=1 at `op_start`), bit 7 of `rd_data` is 0.
- R7: During a busy read, bits 5 to 0 of `rd_data` are 0.
- R8: After `busy` falls, reads return `array_data`. Two consecutive reads therefore show an unchanged bit 6, and bit 7 shows the true stored value.
- R9: Each `op_start` clears the bit-6 sequence, so the first busy read of a new operation again returns 1, whatever the previous operation left.
- R10: Until `op_start` has been seen, `busy` alone does not enable the flags, and reads return `array_data`.
- R11: Changes on `wr_data` after `op_start` do not alter bit 7 during a busy program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Operation engine busy |
| op_start | input | 1 | One-cycle pulse: second command strobe completed |
| op_is_erase | input | 1 | Kind of operation at op_start: 1 erase, 0 program |
| wr_data | input | 8 | Last data byte written by the host |
| rd_strobe | input | 1 | Host read strobe, level |
| array_data | input | 8 | Byte read from the array |
| rd_data | output | 8 | Byte returned to the host |

## Verification
Every result is due one clock edge after the first clock edge that samples `rd_strobe` high. The bench raises the strobe on a falling edge and reads `rd_data` on the next falling edge. It keeps the strobe high for further cycles and checks again to confirm the byte and the flip sequence did not move. `op_start` and `busy` changes are applied one full cycle before any read, so the state they set is in place at the read's edge.

// File: rtl/op_stat_pkg.sv
package op_stat_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_kind_t;
endpackage

// File: rtl/rd_lead_det.sv
module rd_lead_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic lead
);
  logic strobe_q;
  logic strobe_d;

  always_comb strobe_d = strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assign lead = strobe & ~strobe_q;

  a_r4_single_lead: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> !lead);
endmodule

// File: rtl/tog_track.sv
module tog_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic tog_q,
  output logic tog_nxt
);
  logic tog_d;

  assign tog_nxt = ~tog_q;

  always_comb begin
    tog_d = tog_q;
    if (clr)      tog_d = 1'b0;
    else if (adv) tog_d = tog_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tog_q);
  a_r4_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(tog_q));
endmodule

// File: rtl/poll_calc.sv
module poll_calc
  import op_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     wr_bit,
  input  logic     is_erase,
  output logic     poll_bit,
  output op_kind_t kind_q
);
  logic     wbit_q, wbit_d;
  op_kind_t kind_d;

  always_comb begin
    wbit_d = wbit_q;
    kind_d = kind_q;
    if (load) begin
      wbit_d = wr_bit;
      kind_d = is_erase ? OP_ERASE : OP_PROG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbit_q <= 1'b0;
      kind_q <= OP_PROG;
    end else begin
      wbit_q <= wbit_d;
      kind_q <= kind_d;
    end
  end

  assign poll_bit = (kind_q == OP_ERASE) ? 1'b0 : ~wbit_q;

  a_r11_latched_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(wbit_q));
endmodule

// File: rtl/busy_status_rd.sv
module busy_status_rd
  import op_stat_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              op_start,
  input  logic              op_is_erase,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT);
  localparam logic [DATA_W-1:0] REST_MASK = ~FLAG_MASK;

  logic              lead;
  logic              armed_q, armed_d;
  logic              override;
  logic              tog_q, tog_nxt;
  logic              poll_bit;
  op_kind_t          kind_q;
  logic [DATA_W-1:0] byte_d;
  logic [DATA_W-1:0] rd_d;

  rd_lead_det u_lead (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (rd_strobe),
    .lead   (lead)
  );

  // Flags are valid only once the second command strobe has completed.
  always_comb armed_d = op_start | (armed_q & busy);
  assign override = armed_q & busy;

  tog_track u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (op_start),
    .adv     (lead & override & ~op_start),
    .tog_q   (tog_q),
    .tog_nxt (tog_nxt)
  );

  poll_calc u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (op_start),
    .wr_bit   (wr_data[POLL_BIT]),
    .is_erase (op_is_erase),
    .poll_bit (poll_bit),
    .kind_q   (kind_q)
  );

  always_comb begin
    byte_d = '0;
    if (override) begin
      byte_d[POLL_BIT] = poll_bit;
      byte_d[TOG_BIT]  = tog_nxt;
    end else begin
      byte_d = array_data;
    end
  end

  always_comb begin
    rd_d = rd_data;
    if (lead) rd_d = byte_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      rd_data <= '0;
    end else begin
      armed_q <= armed_d;
      rd_data <= rd_d;
    end
  end

  a_r4_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !lead |=> $stable(rd_data));
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && !override) |=> rd_data == $past(array_data));
  a_r7_rest_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && override) |=> (rd_data & REST_MASK) == '0);
  a_r6_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && override && kind_q == OP_ERASE) |=> !rd_data[POLL_BIT]);
  a_r10_unarmed_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && busy && !armed_q) |=> rd_data == $past(array_data));
endmodule

// File: tb/test_busy_status_rd.sv
module test_busy_status_rd;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic       busy;
  logic       op_start;
  logic       op_is_erase;
  logic [7:0] wr_data;
  logic       rd_strobe;
  logic [7:0] array_data;
  logic [7:0] rd_data;

  int n_checks;
  int n_fail;
  bit finished;

  busy_status_rd i_busy_status_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .op_start    (op_start),
    .op_is_erase (op_is_erase),
    .wr_data     (wr_data),
    .rd_strobe   (rd_strobe),
    .array_data  (array_data),
    .rd_data     (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // One read: strobe high for len cycles; returns the byte after the leading edge
  // and checks it stays put while the strobe is held.
  task automatic do_read(input int len, output logic [7:0] val, input string tag);
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    val = rd_data;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      check(rd_data, val, {tag, " R4 hold"});
    end
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_op(input logic erase, input logic [7:0] wd);
    @(negedge clk);
    op_start    = 1'b1;
    op_is_erase = erase;
    wr_data     = wd;
    busy        = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_data, 8'h00, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 8'h00, "R1 after release");
  endtask

  task automatic t_idle;
    logic [7:0] v;
    array_data = 8'h5A;
    do_read(1, v, "R2");
    check(v, 8'h5A, "R2 idle read");
    array_data = 8'hC3;
    do_read(2, v, "R2");
    check(v, 8'hC3, "R2 idle read 2");
  endtask

  task automatic t_gate;
    logic [7:0] v;
    busy = 1'b1;
    array_data = 8'h81;
    @(negedge clk);
    do_read(1, v, "R10");
    check(v, 8'h81, "R10 busy without start");
    busy = 1'b0;
  endtask

  task automatic t_program;
    logic [7:0] v;
    array_data = 8'hFF;
    start_op(1'b0, 8'h3C);
    do_read(1, v, "R3");
    check(v, 8'hC0, "R3 R5 R7 program read 1");
    do_read(4, v, "R4");
    check(v, 8'h80, "R3 R4 program read 2");
    wr_data = 8'h80;
    do_read(1, v, "R11");
    check(v, 8'hC0, "R11 R3 program read 3");
    busy = 1'b0;
    array_data = 8'h3C;
    @(negedge clk);
    do_read(1, v, "R8");
    check(v, 8'h3C, "R8 done read 1");
    do_read(1, v, "R8");
    check(v, 8'h3C, "R8 done read 2");
  endtask

  task automatic t_program_hi;
    logic [7:0] v;
    array_data = 8'h00;
    start_op(1'b0, 8'hA5);
    do_read(1, v, "R5");
    check(v, 8'h40, "R5 program bit7 inverted");
    busy = 1'b0;
    array_data = 8'hA5;
    @(negedge clk);
    do_read(1, v, "R8");
    check(v, 8'hA5, "R8 true data");
  endtask

  task automatic t_erase;
    logic [7:0] v;
    array_data = 8'h7F;
    start_op(1'b1, 8'hD0);
    do_read(1, v, "R6");
    check(v, 8'h40, "R6 erase read 1");
    do_read(1, v, "R6");
    check(v, 8'h00, "R6 erase read 2");
    do_read(1, v, "R6");
    // left after odd number of reads: sequence state is 1
    check(v, 8'h40, "R6 erase read 3");
    busy = 1'b0;
    array_data = 8'hFF;
    @(negedge clk);
    do_read(1, v, "R8");
    check(v, 8'hFF, "R8 erase done");
  endtask

  task automatic t_restart;
    logic [7:0] v;
    start_op(1'b1, 8'h00);
    do_read(1, v, "R9");
    check(v, 8'h40, "R9 first read after new start");
    busy = 1'b0;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; busy = 1'b0; op_start = 1'b0; op_is_erase = 1'b0;
    wr_data = 8'h00; rd_strobe = 1'b0; array_data = 8'h00;
    t_reset();
    t_idle();
    t_gate();
    t_program();
    t_program_hi();
    t_erase();
    t_restart();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule